// File: doc/BRIEF.md
# BCD Real-Time Clock Register Set

This block keeps calendar time as a set of byte-wide registers, each holding a BCD field: seconds, minutes, hours, weekday, day of month, month and a two-digit year. The year is an offset from the `BASE_YEAR` parameter, taken modulo 100, and it is used to decide leap years. A one-cycle `tick` pulse, one per second, advances the time with full carry through every field. Month lengths and leap years are applied when the day of month wraps.

Software reaches the registers through a byte request channel with valid/ready. A request carries a write flag, a 3-bit register select and a data byte. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns one response on a valid/ready channel, and that channel back-pressures the requests: `req_ready` stays low from the edge that accepts a read until the edge where its response is taken with `rsp_ready` high. While `rsp_valid` is high and `rsp_ready` is low, the response byte holds steady. Writes produce no response. Each write is range-checked, and a write whose field is out of range is dropped as a whole. The seconds register holds a stop bit that freezes the clock. The weekday register holds a century bit that software keeps there.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset, reads return 0x00 for control (select 0), seconds (select 1), minutes (select 2), hours (select 3) and year (select 7). They return 0x01 for weekday (select 4), date (select 5) and month (select 6).
- R2: Each accepted tick with the clock running advances seconds in BCD. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R3: Bit 7 of a seconds write is the stop bit and reads back in bit 7 of seconds. While it is set, ticks change no time field. A write with bit 7 clear restarts counting from the value written.
- R4: Writes are checked against these rules:
  - Seconds and minutes use bits 6:0 and must be BCD 00..59.
  - Hours use bits 5:0 and must be BCD 00..23.
  - Weekday uses bits 2:0 and must be 1..7.
  - Date uses bits 5:0 and must be BCD 01..31.
  - Month uses bits 4:0 and must be BCD 01..12.
  - Year uses all 8 bits and must be BCD 00..99.
  - Bits outside a field are ignored and read back as 0, except the stop and century bits.
  - A failing write changes no register.
- R5: When hours wrap from 23 to 00, the weekday steps from 1 up to 7 and then back to 1, and the date advances.
- R6: Date wraps to 01 after the last day of the month and advances the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on day 29 when `BASE_YEAR` plus the year value is a Gregorian leap year, and on day 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Bit 6 of a weekday write is the century bit. Reads of the weekday register return the century bit in bit 6 and the weekday in bits 2:0. Ticks do not change the century bit.
- R8: A control write (select 0) stores the written byte with bits 7 and 5 cleared, then bits 7 and 4 set.
- R9: A read's response appears one cycle after acceptance and holds steady while `rsp_ready` is low. `req_ready` is low while a response is pending. Writes produce no response.
- R10: A tick that arrives in the same cycle as an accepted write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register select |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 8 | Read data byte |

## Verification
The hardest situations to reach are the deep carries: a single tick that ripples from seconds through to the year, or that crosses February in a leap year. Reaching them by counting would take millions of ticks. The stimulus instead loads 23:59:59 together with a chosen date, month and year through validated writes, then issues a single tick and reads every field back. Two other conditions need exact cycle placement, and the stimulus sets each one up directly. A tick raised in the same cycle as a write tests R10. A response held while `rsp_ready` is low tests the back-pressure rule.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_SEC  = 3'd1,
    SEL_MIN  = 3'd2,
    SEL_HOUR = 3'd3,
    SEL_WDAY = 3'd4,
    SEL_DATE = 3'd5,
    SEL_MON  = 3'd6,
    SEL_YEAR = 3'd7
  } sel_e;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hour;
    byte_t wday;
    byte_t date;
    byte_t mon;
    byte_t year;
  } rtc_time_t;

  function automatic logic bcd_ok(byte_t v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcd_val(byte_t v);
    return 10 * int'(v[7:4]) + int'(v[3:0]);
  endfunction
endpackage

// File: rtl/rtc_wr_check.sv
module rtc_wr_check
  import rtc_pkg::*;
(
  input  sel_e  sel,
  input  byte_t data,
  output byte_t field,
  output logic  ok
);
  always_comb begin
    field = data;
    ok    = 1'b1;
    case (sel)
      SEL_CTRL: ok = 1'b1;
      SEL_SEC, SEL_MIN: begin
        field = data & 8'h7F;
        ok    = bcd_ok(field) && (field <= 8'h59);
      end
      SEL_HOUR: begin
        field = data & 8'h3F;
        ok    = bcd_ok(field) && (field <= 8'h23);
      end
      SEL_WDAY: begin
        field = data & 8'h07;
        ok    = (field != 8'h00);
      end
      SEL_DATE: begin
        field = data & 8'h3F;
        ok    = bcd_ok(field) && (field != 8'h00) && (field <= 8'h31);
      end
      SEL_MON: begin
        field = data & 8'h1F;
        ok    = bcd_ok(field) && (field != 8'h00) && (field <= 8'h12);
      end
      SEL_YEAR: ok = bcd_ok(data);
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  wr_en,
  input  sel_e  wr_sel,
  input  byte_t wr_data,
  input  byte_t wr_field,
  input  logic  wr_ok,
  input  sel_e  rd_sel,
  output byte_t rd_data
);
  localparam int BY4   = int'(BASE_YEAR % 4);
  localparam int BY100 = int'(BASE_YEAR % 100);
  localparam int BY400 = int'(BASE_YEAR % 400);

  rtc_time_t tm_q, nxt;
  logic  stop_q, cent_q;
  byte_t ctrl_q, last_day;

  function automatic logic is_leap(byte_t yr);
    int  off;
    logic d4, d100, d400;
    off  = bcd_val(yr);
    d4   = ((BY4 + off) % 4) == 0;
    d100 = ((BY100 + off) == 0) || ((BY100 + off) == 100);
    d400 = ((BY400 + off) == 0) || ((BY400 + off) == 400);
    return d4 && (!d100 || d400);
  endfunction

  function automatic byte_t month_len(byte_t mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  always_comb begin
    nxt      = tm_q;
    last_day = month_len(tm_q.mon, is_leap(tm_q.year));
    if (tm_q.sec != 8'h59) nxt.sec = bcd_inc(tm_q.sec);
    else begin
      nxt.sec = 8'h00;
      if (tm_q.min != 8'h59) nxt.min = bcd_inc(tm_q.min);
      else begin
        nxt.min = 8'h00;
        if (tm_q.hour != 8'h23) nxt.hour = bcd_inc(tm_q.hour);
        else begin
          nxt.hour = 8'h00;
          nxt.wday = (tm_q.wday >= 8'h07) ? 8'h01 : tm_q.wday + 8'h01;
          if (tm_q.date < last_day) nxt.date = bcd_inc(tm_q.date);
          else begin
            nxt.date = 8'h01;
            if (tm_q.mon < 8'h12) nxt.mon = bcd_inc(tm_q.mon);
            else begin
              nxt.mon  = 8'h01;
              nxt.year = (tm_q.year == 8'h99) ? 8'h00 : bcd_inc(tm_q.year);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm_q   <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                  date: 8'h01, mon: 8'h01, year: 8'h00};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      ctrl_q <= 8'h00;
    end else if (wr_en) begin
      if (wr_ok) begin
        case (wr_sel)
          SEL_CTRL: ctrl_q <= (wr_data & 8'h5F) | 8'h90;
          SEL_SEC:  begin tm_q.sec <= wr_field; stop_q <= wr_data[7]; end
          SEL_MIN:  tm_q.min  <= wr_field;
          SEL_HOUR: tm_q.hour <= wr_field;
          SEL_WDAY: begin tm_q.wday <= wr_field; cent_q <= wr_data[6]; end
          SEL_DATE: tm_q.date <= wr_field;
          SEL_MON:  tm_q.mon  <= wr_field;
          SEL_YEAR: tm_q.year <= wr_field;
          default:  ctrl_q <= ctrl_q;
        endcase
      end
    end else if (tick && !stop_q) begin
      tm_q <= nxt;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = ctrl_q;
      SEL_SEC:  rd_data = {stop_q, tm_q.sec[6:0]};
      SEL_MIN:  rd_data = tm_q.min;
      SEL_HOUR: rd_data = tm_q.hour;
      SEL_WDAY: rd_data = {1'b0, cent_q, 3'b000, tm_q.wday[2:0]};
      SEL_DATE: rd_data = tm_q.date;
      SEL_MON:  rd_data = tm_q.mon;
      SEL_YEAR: rd_data = tm_q.year;
      default:  rd_data = 8'h00;
    endcase
  end

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(tm_q.sec) && (tm_q.sec <= 8'h59));
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> $stable(tm_q));
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> ($stable(tm_q) && $stable(stop_q) && $stable(cent_q) && $stable(ctrl_q)));
  p_month_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q.mon >= 8'h01) && (tm_q.mon <= 8'h12));
  p_ctrl_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));
  p_tick_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_SEC) |=> $stable(tm_q.sec));
endmodule

// File: rtl/rtc_req_port.sv
module rtc_req_port
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  output logic  req_ready,
  input  logic  req_write,
  input  byte_t rd_data,
  output logic  wr_en,
  output logic  rsp_valid,
  input  logic  rsp_ready,
  output byte_t rsp_rdata
);
  logic take_rd;

  assign req_ready = !rsp_valid;
  assign wr_en     = req_valid && req_ready && req_write;
  assign take_rd   = req_valid && req_ready && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else if (take_rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_read_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [2:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_rdata
);
  sel_e  sel;
  byte_t field, rd_data;
  logic  ok, wr_en;

  assign sel = sel_e'(req_addr);

  rtc_wr_check u_check (
    .sel   (sel),
    .data  (req_wdata),
    .field (field),
    .ok    (ok)
  );

  rtc_time_core #(.BASE_YEAR(BASE_YEAR)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_sel   (sel),
    .wr_data  (req_wdata),
    .wr_field (field),
    .wr_ok    (ok),
    .rd_sel   (sel),
    .rd_data  (rd_data)
  );

  rtc_req_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: tb/rtc_bcd_regs_test.sv
module rtc_bcd_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
                         A_WDAY = 3'd4, A_DATE = 3'd5, A_MON = 3'd6, A_YEAR = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0] req_addr = 3'd0;
  logic [7:0] req_wdata = 8'h00;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_exp;
  string m_tag;
  bit done = 0;

  rtc_bcd_regs uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] a, input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; tick = with_tick;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
  endtask

  task automatic get(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic last_second;
    put(A_HOUR, 8'h23, 0); put(A_MIN, 8'h59, 0); put(A_SEC, 8'h59, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: compare responses against the queue
  always begin
    @(negedge clk); #2;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected response actual %h expected none", rsp_rdata);
      end else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        check(rsp_rdata, m_exp, m_tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    get(A_CTRL, 8'h00, "R1 ctrl");  get(A_SEC, 8'h00, "R1 sec");
    get(A_MIN, 8'h00, "R1 min");    get(A_HOUR, 8'h00, "R1 hour");
    get(A_WDAY, 8'h01, "R1 wday");  get(A_DATE, 8'h01, "R1 date");
    get(A_MON, 8'h01, "R1 month");  get(A_YEAR, 8'h00, "R1 year");

    // R8 control transform
    put(A_CTRL, 8'h2F, 0); get(A_CTRL, 8'h9F, "R8 ctrl 2F");
    put(A_CTRL, 8'h00, 0); get(A_CTRL, 8'h90, "R8 ctrl 00");
    put(A_CTRL, 8'hFF, 0); get(A_CTRL, 8'hDF, "R8 ctrl FF");

    // R2 counting and carries
    put(A_SEC, 8'h58, 0); put(A_MIN, 8'h59, 0); put(A_HOUR, 8'h12, 0);
    ticks(1); get(A_SEC, 8'h59, "R2 sec step");
    ticks(1);
    get(A_SEC, 8'h00, "R2 sec wrap"); get(A_MIN, 8'h00, "R2 min wrap");
    get(A_HOUR, 8'h13, "R2 hour carry");
    ticks(10); get(A_SEC, 8'h10, "R2 bcd digit carry");

    // R3 stop bit
    put(A_SEC, 8'hB0, 0); ticks(3);
    get(A_SEC, 8'hB0, "R3 frozen sec"); get(A_MIN, 8'h00, "R3 frozen min");
    put(A_SEC, 8'h30, 0); ticks(2);
    get(A_SEC, 8'h32, "R3 resumed");

    // R4 validation
    put(A_SEC, 8'h5A, 0); put(A_SEC, 8'hE0, 0);
    get(A_SEC, 8'h32, "R4 bad sec dropped");
    put(A_MIN, 8'h60, 0); get(A_MIN, 8'h00, "R4 bad min dropped");
    put(A_HOUR, 8'h24, 0); get(A_HOUR, 8'h13, "R4 bad hour dropped");
    put(A_MON, 8'h13, 0); put(A_MON, 8'h00, 0); get(A_MON, 8'h01, "R4 bad month dropped");
    put(A_DATE, 8'h32, 0); put(A_DATE, 8'h00, 0); get(A_DATE, 8'h01, "R4 bad date dropped");
    put(A_YEAR, 8'hA0, 0); get(A_YEAR, 8'h00, "R4 bad year dropped");
    put(A_WDAY, 8'h40, 0); get(A_WDAY, 8'h01, "R4 bad wday dropped");
    put(A_HOUR, 8'hC5, 0); get(A_HOUR, 8'h05, "R4 hour upper bits ignored");
    put(A_MON, 8'h12, 0);  get(A_MON, 8'h12, "R4 month 12 accepted");
    put(A_DATE, 8'h31, 0); get(A_DATE, 8'h31, "R4 date 31 accepted");
    put(A_YEAR, 8'h99, 0); get(A_YEAR, 8'h99, "R4 year 99 accepted");

    // R5 and R7 day rollover with century bit
    put(A_WDAY, 8'h47, 0); put(A_DATE, 8'h15, 0); put(A_MON, 8'h06, 0);
    put(A_YEAR, 8'h00, 0); last_second(); ticks(1);
    get(A_SEC, 8'h00, "R5 sec"); get(A_MIN, 8'h00, "R5 min"); get(A_HOUR, 8'h00, "R5 hour");
    get(A_DATE, 8'h16, "R5 date"); get(A_MON, 8'h06, "R5 month");
    get(A_WDAY, 8'h41, "R7 century kept, weekday 7 to 1");
    put(A_WDAY, 8'h03, 0); last_second(); ticks(1);
    get(A_WDAY, 8'h04, "R5 weekday step, R7 century cleared");

    // R6 month lengths and leap years (base year 2000)
    put(A_YEAR, 8'h00, 0); put(A_MON, 8'h02, 0); put(A_DATE, 8'h28, 0);
    last_second(); ticks(1);
    get(A_DATE, 8'h29, "R6 leap feb 29"); get(A_MON, 8'h02, "R6 leap month");
    last_second(); ticks(1);
    get(A_DATE, 8'h01, "R6 leap feb end"); get(A_MON, 8'h03, "R6 march");
    put(A_YEAR, 8'h01, 0); put(A_MON, 8'h02, 0); put(A_DATE, 8'h28, 0);
    last_second(); ticks(1);
    get(A_DATE, 8'h01, "R6 non-leap feb end"); get(A_MON, 8'h03, "R6 non-leap march");
    put(A_MON, 8'h04, 0); put(A_DATE, 8'h30, 0); last_second(); ticks(1);
    get(A_DATE, 8'h01, "R6 april end"); get(A_MON, 8'h05, "R6 may");
    put(A_MON, 8'h09, 0); put(A_DATE, 8'h30, 0); last_second(); ticks(1);
    get(A_MON, 8'h10, "R6 september to october");
    put(A_MON, 8'h01, 0); put(A_DATE, 8'h30, 0); last_second(); ticks(1);
    get(A_DATE, 8'h31, "R6 january 31");
    put(A_YEAR, 8'h99, 0); put(A_MON, 8'h12, 0); put(A_DATE, 8'h31, 0);
    last_second(); ticks(1);
    get(A_YEAR, 8'h00, "R6 year wrap"); get(A_MON, 8'h01, "R6 month wrap");
    get(A_DATE, 8'h01, "R6 date wrap");

    // R10 tick coinciding with a write
    put(A_SEC, 8'h10, 0); put(A_MIN, 8'h05, 1);
    get(A_SEC, 8'h10, "R10 tick dropped"); get(A_MIN, 8'h05, "R10 write kept");
    put(A_SEC, 8'h20, 1); get(A_SEC, 8'h20, "R10 sec write with tick");

    // R9 back-pressure on the response
    @(negedge clk); rsp_ready = 1'b0;
    get(A_MIN, 8'h05, "R9 stalled read data");
    repeat (3) @(negedge clk);
    check({7'd0, rsp_valid}, 8'h01, "R9 response held");
    check({7'd0, req_ready}, 8'h00, "R9 request blocked");
    check(rsp_rdata, 8'h05, "R9 data stable under stall");
    rsp_ready = 1'b1;
    put(A_MIN, 8'h06, 0); get(A_MIN, 8'h06, "R9 write after stall");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule